// File: doc/BRIEF.md
# Debug Host Bus-Access and Mailbox Port

This block takes host debug requests that have already been decoded and serves them in one of two ways. The requests are word write, half-word write, byte write and word read. Each request carries a 32-bit data word, a 32-bit address and an optional "wait for trigger" flag.

In access mode the block masters an on-chip bus for single transfers. A sub-word write still carries a full 32-bit data word. Only the byte lanes picked by the low address bits are enabled. Word reads return their result in the port's data register.

In communication mode the bus is never used. A host request only raises a flag in a status word that CPU software polls. The host and the CPU then pass the value through a data register that both sides share. Communication mode is in force after reset. The mode is changed by a separate mode-write strobe.

A request in access mode may be armed instead of started. An armed request waits for a rising edge on an external trigger input. Each edge releases exactly one armed transfer.

Top module: `dbg_access_port`

## Requirements
- R1: After reset the port is in communication mode. bus_valid, host_busy, host_nack and cpu_status are 0, and the data register (host_rdata, cpu_rdata) is 0.
- R2: In access mode a byte write (host_cmd=2) drives bus_be to 4'b0001, 4'b0010, 4'b0100 or 4'b1000 for host_addr[1:0] = 0, 1, 2, 3. The bus transfer also carries bus_write=1, the full host_addr and the unmodified 32-bit host_wdata.
- R3: In access mode a half-word write (host_cmd=1) drives bus_be=4'b0011 when host_addr[1]=0 and 4'b1100 when host_addr[1]=1. host_addr[0] has no effect.
- R4: In access mode a word write (host_cmd=0) and a word read (host_cmd=3) drive bus_be=4'b1111. When a read completes, bus_rdata is captured into the data register.
- R5: An access-mode transfer holds bus_valid, bus_addr, bus_be, bus_wdata and bus_write stable until a cycle with bus_ready. host_busy stays 1 until then. A request that arrives while host_busy=1 raises host_nack for one cycle and leaves the transfer in progress unchanged.
- R6: In communication mode no request raises bus_valid, and host_addr has no effect.
- R7: In communication mode an accepted word write loads host_wdata into the data register and sets cpu_status[0] (host wants to send). A cpu_data_rd pulse clears that bit.
- R8: In communication mode an accepted word read sets cpu_status[1] (host wants to receive). A cpu_data_wr pulse loads cpu_wdata into the data register and clears that bit.
- R9: A communication-mode word write while cpu_status[0]=1 or cpu_data_wr=1 is refused with host_nack, and the data register is left unchanged. A word read while cpu_status[1]=1 is refused with host_nack.
- R10: In communication mode half-word and byte writes are refused with host_nack and change no status bit.
- R11: A request accepted with host_arm=1 in access mode raises host_busy without bus_valid. The next rising edge of trig_in starts the transfer. A trig_in held high starts no further armed transfer.
- R12: A trig_in rising edge while no transfer is armed has no effect.
- R13: A mode write (mode_wr) while host_busy=1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_val | input | 1 | Mode to write: 1 access, 0 communication |
| host_cmd_valid | input | 1 | Host request strobe |
| host_cmd | input | 2 | 0 word write, 1 half-word write, 2 byte write, 3 word read |
| host_addr | input | 32 | Host address register |
| host_wdata | input | 32 | Host data word |
| host_arm | input | 1 | Hold the access transfer until a trigger edge |
| host_busy | output | 1 | Access transfer armed or in progress |
| host_nack | output | 1 | One-cycle pulse: last request refused |
| host_rdata | output | 32 | Data register, host view |
| trig_in | input | 1 | External debug trigger |
| bus_valid | output | 1 | Bus request valid |
| bus_write | output | 1 | 1 write, 0 read |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_be | output | 4 | Byte-lane enables |
| bus_ready | input | 1 | Bus completes the transfer |
| bus_rdata | input | 32 | Bus read data |
| cpu_data_rd | input | 1 | CPU reads the data register |
| cpu_data_wr | input | 1 | CPU writes the data register |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | Data register, CPU view |
| cpu_status | output | 2 | Bit 0 host wants to send, bit 1 host wants to receive |

## Verification
The hardest case to reach is the one-shot behaviour of the trigger. An armed transfer must be released by an edge and not by a level. A test only exposes a level-sensitive design if a second transfer is armed while the trigger is still high from the edge that started the first one. The bench does exactly that. It keeps trig_in high through the completion of the first armed read, arms a second read, and checks that bus_valid stays low until trig_in falls and rises again. It also pulses the trigger while nothing is armed, and later checks that no stale transfer appears.

// File: rtl/dbg_port_pkg.sv
package dbg_port_pkg;

    localparam int unsigned DBG_AW  = 32;
    localparam int unsigned DBG_DW  = 32;
    localparam int unsigned DBG_BEW = DBG_DW / 8;
    localparam int unsigned DBG_LSW = $clog2(DBG_BEW);

    typedef enum logic [1:0] {
        CMD_WR_WORD = 2'd0,
        CMD_WR_HALF = 2'd1,
        CMD_WR_BYTE = 2'd2,
        CMD_RD_WORD = 2'd3
    } host_cmd_e;

    typedef enum logic {
        MODE_COMM   = 1'b0,
        MODE_ACCESS = 1'b1
    } port_mode_e;

    typedef struct packed {
        port_mode_e          mode;
        logic                armed;
        logic                bvalid;
        logic                bwrite;
        logic [DBG_AW-1:0]   baddr;
        logic [DBG_DW-1:0]   bwdata;
        logic [DBG_BEW-1:0]  bbe;
        logic [DBG_DW-1:0]   data;
        logic                nack;
    } port_state_t;

endpackage

// File: rtl/dbg_lane_sel.sv
module dbg_lane_sel
    import dbg_port_pkg::*;
(
    input  logic [1:0]          cmd,
    input  logic [DBG_LSW-1:0]  addr_lo,
    output logic [DBG_BEW-1:0]  be
);

    host_cmd_e cmd_e;
    assign cmd_e = host_cmd_e'(cmd);

    for (genvar i = 0; i < DBG_BEW; i++) begin : g_lane
        logic byte_hit;
        logic half_hit;
        assign byte_hit = (addr_lo == DBG_LSW'(i));
        assign half_hit = (addr_lo[DBG_LSW-1:1] == (DBG_LSW-1)'(i / 2));
        always_comb begin
            unique case (cmd_e)
                CMD_WR_BYTE: be[i] = byte_hit;
                CMD_WR_HALF: be[i] = half_hit;
                default:     be[i] = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/dbg_trig_edge.sv
module dbg_trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic trig_rise
);

    logic trig_d, trig_q;

    always_comb begin
        trig_d = trig_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_d;
    end

    assign trig_rise = trig_in & ~trig_q;

endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_send,
    input  logic       set_recv,
    input  logic       cpu_rd,
    input  logic       cpu_wr,
    output logic [1:0] status
);

    typedef struct packed {
        logic recv;
        logic send;
    } flags_t;

    flags_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        if (cpu_rd)   flg_d.send = 1'b0;
        if (cpu_wr)   flg_d.recv = 1'b0;
        if (set_send) flg_d.send = 1'b1;
        if (set_recv) flg_d.recv = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign status = {flg_q.recv, flg_q.send};

    // R7
    send_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flg_q.send) |-> $past(set_send));

    // R8
    recv_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flg_q.recv) |-> $past(cpu_wr));

endmodule

// File: rtl/dbg_access_port.sv
module dbg_access_port
    import dbg_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              mode_val,
    input  logic              host_cmd_valid,
    input  logic [1:0]        host_cmd,
    input  logic [31:0]       host_addr,
    input  logic [31:0]       host_wdata,
    input  logic              host_arm,
    output logic              host_busy,
    output logic              host_nack,
    output logic [31:0]       host_rdata,
    input  logic              trig_in,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [31:0]       bus_addr,
    output logic [31:0]       bus_wdata,
    output logic [3:0]        bus_be,
    input  logic              bus_ready,
    input  logic [31:0]       bus_rdata,
    input  logic              cpu_data_rd,
    input  logic              cpu_data_wr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic [1:0]        cpu_status
);

    port_state_t        st_d, st_q;
    logic [DBG_BEW-1:0] lane_be;
    logic               trig_rise;
    logic               set_send_d, set_recv_d;
    logic               in_comm;
    logic               busy;
    host_cmd_e          cmd_e;

    assign cmd_e   = host_cmd_e'(host_cmd);
    assign in_comm = (st_q.mode == MODE_COMM);
    assign busy    = st_q.armed | st_q.bvalid;

    dbg_lane_sel u_lane (
        .cmd     (host_cmd),
        .addr_lo (host_addr[DBG_LSW-1:0]),
        .be      (lane_be)
    );

    dbg_trig_edge u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .trig_rise (trig_rise)
    );

    dbg_mailbox u_mbox (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_send (set_send_d),
        .set_recv (set_recv_d),
        .cpu_rd   (cpu_data_rd & in_comm),
        .cpu_wr   (cpu_data_wr & in_comm),
        .status   (cpu_status)
    );

    always_comb begin
        st_d       = st_q;
        st_d.nack  = 1'b0;
        set_send_d = 1'b0;
        set_recv_d = 1'b0;

        // bus completion
        if (st_q.bvalid && bus_ready) begin
            st_d.bvalid = 1'b0;
            if (!st_q.bwrite) st_d.data = bus_rdata;
        end

        // armed transfer released by trigger edge
        if (st_q.armed && trig_rise) begin
            st_d.armed  = 1'b0;
            st_d.bvalid = 1'b1;
        end

        if (mode_wr && !busy) st_d.mode = port_mode_e'(mode_val);

        if (in_comm && cpu_data_wr) st_d.data = cpu_wdata;

        if (host_cmd_valid) begin
            if (!in_comm) begin
                if (busy) begin
                    st_d.nack = 1'b1;
                end else begin
                    st_d.bwrite = (cmd_e != CMD_RD_WORD);
                    st_d.baddr  = host_addr;
                    st_d.bwdata = host_wdata;
                    st_d.bbe    = lane_be;
                    if (host_arm) st_d.armed  = 1'b1;
                    else          st_d.bvalid = 1'b1;
                end
            end else begin
                unique case (cmd_e)
                    CMD_WR_WORD: begin
                        if (cpu_status[0] || cpu_data_wr) begin
                            st_d.nack = 1'b1;
                        end else begin
                            st_d.data  = host_wdata;
                            set_send_d = 1'b1;
                        end
                    end
                    CMD_RD_WORD: begin
                        if (cpu_status[1]) st_d.nack = 1'b1;
                        else               set_recv_d = 1'b1;
                    end
                    default: st_d.nack = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MODE_COMM;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_busy  = busy;
    assign host_nack  = st_q.nack;
    assign host_rdata = st_q.data;
    assign cpu_rdata  = st_q.data;
    assign bus_valid  = st_q.bvalid;
    assign bus_write  = st_q.bwrite;
    assign bus_addr   = st_q.baddr;
    assign bus_wdata  = st_q.bwdata;
    assign bus_be     = st_q.bbe;

    // R5
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
            $stable(bus_be) && $stable(bus_wdata) && $stable(bus_write)));

    // R6
    comm_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_comm && !busy) |=> !$rose(bus_valid));

    // R2
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> ($countones(bus_be) == 1 || bus_be == 4'b0011 ||
                       bus_be == 4'b1100 || bus_be == 4'b1111));

    // R11
    arm_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.armed) |-> bus_valid);

    // R13
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(st_q.mode));

endmodule

// File: tb/dbg_access_port_tb.sv
module dbg_access_port_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_wr, mode_val;
    logic        host_cmd_valid;
    logic [1:0]  host_cmd;
    logic [31:0] host_addr, host_wdata;
    logic        host_arm;
    logic        host_busy, host_nack;
    logic [31:0] host_rdata;
    logic        trig_in;
    logic        bus_valid, bus_write;
    logic [31:0] bus_addr, bus_wdata;
    logic [3:0]  bus_be;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        cpu_data_rd, cpu_data_wr;
    logic [31:0] cpu_wdata, cpu_rdata;
    logic [1:0]  cpu_status;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dbg_access_port u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_val(mode_val),
        .host_cmd_valid(host_cmd_valid), .host_cmd(host_cmd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_arm(host_arm),
        .host_busy(host_busy), .host_nack(host_nack), .host_rdata(host_rdata),
        .trig_in(trig_in), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .cpu_data_rd(cpu_data_rd), .cpu_data_wr(cpu_data_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_status(cpu_status)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(logic [1:0] cmd, logic [31:0] addr, logic [31:0] data, logic arm);
        @(negedge clk);
        host_cmd_valid = 1'b1; host_cmd = cmd; host_addr = addr;
        host_wdata = data; host_arm = arm;
        @(negedge clk);
        host_cmd_valid = 1'b0; host_arm = 1'b0;
    endtask

    task automatic complete(logic [31:0] rdata);
        bus_ready = 1'b1; bus_rdata = rdata;
        @(negedge clk);
        bus_ready = 1'b0;
    endtask

    task automatic set_mode(logic m);
        @(negedge clk);
        mode_wr = 1'b1; mode_val = m;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 bus_valid", 32'(bus_valid), 0);
        check("R1 busy", 32'(host_busy), 0);
        check("R1 nack", 32'(host_nack), 0);
        check("R1 status", 32'(cpu_status), 0);
        check("R1 data", host_rdata, 0);
    endtask

    task automatic t_comm_send;
        send(2'd0, 32'hFFFF_FFF3, 32'hCAFE_0001, 1'b0);
        check("R6 no bus", 32'(bus_valid), 0);
        check("R7 status send", 32'(cpu_status), 32'h1);
        check("R7 data", cpu_rdata, 32'hCAFE_0001);
        send(2'd0, 32'h0, 32'hDEAD_0002, 1'b0);
        check("R9 nack send", 32'(host_nack), 1);
        check("R9 data kept", host_rdata, 32'hCAFE_0001);
        @(negedge clk); cpu_data_rd = 1'b1;
        @(negedge clk); cpu_data_rd = 1'b0;
        check("R7 cleared", 32'(cpu_status), 0);
    endtask

    task automatic t_comm_recv;
        send(2'd3, 32'h1234_5678, 32'h0, 1'b0);
        check("R8 status recv", 32'(cpu_status), 32'h2);
        check("R6 no bus read", 32'(bus_valid), 0);
        send(2'd3, 32'h0, 32'h0, 1'b0);
        check("R9 nack recv", 32'(host_nack), 1);
        @(negedge clk); cpu_data_wr = 1'b1; cpu_wdata = 32'h0BAD_F00D;
        @(negedge clk); cpu_data_wr = 1'b0;
        check("R8 cleared", 32'(cpu_status), 0);
        check("R8 data", host_rdata, 32'h0BAD_F00D);
        // collision of host word write with CPU write
        @(negedge clk);
        cpu_data_wr = 1'b1; cpu_wdata = 32'h5555_AAAA;
        host_cmd_valid = 1'b1; host_cmd = 2'd0; host_wdata = 32'h7777_7777; host_arm = 1'b0;
        @(negedge clk);
        cpu_data_wr = 1'b0; host_cmd_valid = 1'b0;
        check("R9 collide nack", 32'(host_nack), 1);
        check("R9 collide data", host_rdata, 32'h5555_AAAA);
        check("R9 collide status", 32'(cpu_status), 0);
    endtask

    task automatic t_comm_sub;
        send(2'd1, 32'h0, 32'h1111_2222, 1'b0);
        check("R10 half nack", 32'(host_nack), 1);
        send(2'd2, 32'h0, 32'h1111_2222, 1'b0);
        check("R10 byte nack", 32'(host_nack), 1);
        check("R10 status", 32'(cpu_status), 0);
        check("R10 data", host_rdata, 32'h5555_AAAA);
    endtask

    task automatic t_byte;
        for (int a = 0; a < 4; a++) begin
            send(2'd2, 32'h4000_0100 + 32'(a), 32'hA1B2_C3D4, 1'b0);
            check("R2 valid", 32'(bus_valid), 1);
            check("R2 be", 32'(bus_be), 32'(4'b0001 << a));
            check("R2 addr", bus_addr, 32'h4000_0100 + 32'(a));
            check("R2 wdata", bus_wdata, 32'hA1B2_C3D4);
            check("R2 write", 32'(bus_write), 1);
            complete(32'h0);
            check("R2 done", 32'(bus_valid), 0);
        end
    endtask

    task automatic t_half;
        for (int a = 0; a < 4; a++) begin
            send(2'd1, 32'h2000_0000 + 32'(a), 32'h0102_0304, 1'b0);
            check("R3 be", 32'(bus_be), (a < 2) ? 32'h3 : 32'hC);
            complete(32'h0);
        end
    endtask

    task automatic t_word;
        send(2'd0, 32'h3000_0000, 32'h8765_4321, 1'b0);
        check("R4 wr be", 32'(bus_be), 32'hF);
        complete(32'h0);
        send(2'd3, 32'h3000_0004, 32'h0, 1'b0);
        check("R4 rd be", 32'(bus_be), 32'hF);
        check("R4 rd dir", 32'(bus_write), 0);
        complete(32'h1357_9BDF);
        check("R4 rd data", host_rdata, 32'h1357_9BDF);
    endtask

    task automatic t_hold;
        send(2'd2, 32'h5000_0002, 32'hFEED_BEEF, 1'b0);
        repeat (3) @(negedge clk);
        check("R5 held valid", 32'(bus_valid), 1);
        check("R5 busy", 32'(host_busy), 1);
        send(2'd0, 32'h6000_0000, 32'h0, 1'b0);
        check("R5 nack", 32'(host_nack), 1);
        check("R5 addr kept", bus_addr, 32'h5000_0002);
        check("R5 be kept", 32'(bus_be), 32'h4);
        set_mode(1'b0);
        complete(32'h0);
        send(2'd0, 32'h6000_0000, 32'h0, 1'b0);
        check("R13 still access", 32'(bus_valid), 1);
        complete(32'h0);
    endtask

    task automatic t_trig;
        @(negedge clk); trig_in = 1'b1;
        @(negedge clk); trig_in = 1'b0;
        @(negedge clk);
        check("R12 no start", 32'(bus_valid), 0);
        check("R12 not busy", 32'(host_busy), 0);
        send(2'd3, 32'h7000_0000, 32'h0, 1'b1);
        @(negedge clk);
        check("R11 armed busy", 32'(host_busy), 1);
        check("R11 armed idle bus", 32'(bus_valid), 0);
        trig_in = 1'b1;
        @(negedge clk);
        check("R11 started", 32'(bus_valid), 1);
        complete(32'h2468_ACE0);
        check("R11 data", host_rdata, 32'h2468_ACE0);
        send(2'd3, 32'h7000_0004, 32'h0, 1'b1);
        repeat (2) @(negedge clk);
        check("R11 level no start", 32'(bus_valid), 0);
        trig_in = 1'b0;
        @(negedge clk); trig_in = 1'b1;
        @(negedge clk);
        check("R11 second edge", 32'(bus_valid), 1);
        check("R11 second addr", bus_addr, 32'h7000_0004);
        complete(32'h0);
        trig_in = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; mode_wr = 1'b0; mode_val = 1'b0;
        host_cmd_valid = 1'b0; host_cmd = 2'd0; host_addr = '0;
        host_wdata = '0; host_arm = 1'b0; trig_in = 1'b0;
        bus_ready = 1'b0; bus_rdata = '0;
        cpu_data_rd = 1'b0; cpu_data_wr = 1'b0; cpu_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_comm_send();
        t_comm_recv();
        t_comm_sub();
        set_mode(1'b1);
        t_byte();
        t_half();
        t_word();
        t_hold();
        t_trig();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule